// File: doc/BRIEF.md
# Big-Endian Load/Store Alignment Unit

This unit sits between the execute stage of a 32-bit processor and a byte-addressed data memory that is one word wide and answers one cycle after each request. For every request it adds a sign-extended 16-bit displacement to a base value to form the effective byte address, and checks that the access is naturally aligned for its size. For a store it steers the byte, halfword or word onto the correct lanes and raises the matching byte enables. For a load it takes the word the memory returns one cycle later, picks out the addressed bytes and widens them to 32 bits.

Byte order is big-endian: the lowest byte address inside a word maps to the most significant lane. A request that breaks alignment, or uses the reserved size code, does not reach memory. It is reported one cycle later on a single-cycle flag. A new request can be accepted every clock cycle.

Top module: `be_lsu_align`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `rsp_valid`, `misalign`, `mem_en` and `mem_we` are 0 and `rsp_data` reads 0.
- R2: The effective address is `req_base` plus `req_offset` sign-extended to 32 bits, modulo 2^32. `mem_addr` carries that address with its two low bits cleared, in the request cycle.
- R3: Size code `req_size` is 00 byte, 01 halfword, 10 word, and 11 is reserved. A byte is legal at any address, a halfword needs address bit 0 clear, and a word needs address bits 1:0 both clear. The reserved code is never legal.
- R4: An illegal request (R3) holds `mem_en` and `mem_we` low in its own cycle. It raises `misalign` for exactly the next cycle and produces no `rsp_valid`. Neither memory nor `rsp_data` changes because of it.
- R5: `mem_be` bit 3 is the lane of byte offset 0 and bit 0 is the lane of offset 3. A byte store enables the single lane 3-k for offset k. A halfword store enables 1100 at offset 0 and 0011 at offset 2. A word store enables 1111. `mem_be` is 0000 when `mem_we` is low.
- R6: On a store, `mem_wdata` repeats `req_wdata[7:0]` into all four lanes for a byte, `req_wdata[15:0]` into both halves for a halfword, and passes `req_wdata` unchanged for a word.
- R7: A load result takes its bytes in big-endian order from the returned word. A byte at offset k comes from bits [31-8k:24-8k]. A halfword comes from bits [31:16] at offset 0 and from bits [15:0] at offset 2. A word is taken whole.
- R8: With `req_signed` = 1, byte and halfword loads are sign-extended to 32 bits; with 0 they are zero-extended. Word loads are not affected by the flag.
- R9: A legal request drives `mem_en` in its own cycle, and `mem_we` as well if it is a store. A legal load returns its result with `rsp_valid` high exactly one cycle later. Stores never raise `rsp_valid`.
- R10: In every cycle without `rsp_valid`, `rsp_data` keeps the value of the most recent load result.
- R11: Requests may come in back-to-back cycles. A load issued in the cycle right after a store to the same word sees the stored data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | Access size code |
| req_signed | input | 1 | Sign-extend narrow loads |
| req_base | input | 32 | Base register value |
| req_offset | input | 16 | Signed displacement |
| req_wdata | input | 32 | Store data, right-aligned |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_be | output | 4 | Store lane enables |
| mem_wdata | output | 32 | Lane-steered store data |
| mem_rdata | input | 32 | Word returned one cycle after a read |
| rsp_valid | output | 1 | Load result valid |
| rsp_data | output | 32 | Extended load result |
| misalign | output | 1 | Previous request was rejected |

## Verification
Each load width is tried at every byte offset, using bytes with the top bit both set and clear under both extension settings. This separates lane reversal errors from sign errors. Narrow stores carry junk in their upper source bits and are read back as whole words, which exposes wrong enables or wrong replication. Rejected accesses cover every illegal offset for halfwords and words plus the reserved size, for both directions, each followed by a read-back that shows memory and the held result untouched. Negative displacements and a base that wraps past 2^32 test the sign extension and the modular addition.

// File: rtl/be_lsu_pkg.sv
package be_lsu_pkg;

    localparam int unsigned XLEN   = 32;
    localparam int unsigned IMM_W  = 16;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned LANES  = XLEN / BYTE_W;
    localparam int unsigned OFS_W  = $clog2(LANES);

    // Access size as carried on the request
    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } acc_size_e;

    // Context kept from the request cycle to the response cycle
    typedef struct packed {
        logic                 load;
        acc_size_e            size;
        logic                 sext;
        logic [OFS_W-1:0]     boff;
    } ld_ctx_t;

    // Widen a narrow field to the full datapath, sign or zero fill
    function automatic logic [XLEN-1:0] widen(input logic [XLEN-1:0] v,
                                              input int unsigned     bits,
                                              input logic            sext);
        logic [XLEN-1:0] r;
        logic            fill;
        fill = sext & v[bits-1];
        for (int i = 0; i < XLEN; i++) begin
            r[i] = (i < int'(bits)) ? v[i] : fill;
        end
        return r;
    endfunction

endpackage

// File: rtl/be_agen.sv
module be_agen
    import be_lsu_pkg::*;
#(
    parameter int unsigned AW = XLEN,
    parameter int unsigned IW = IMM_W,
    parameter int unsigned OW = OFS_W
) (
    input  logic [AW-1:0] base,
    input  logic [IW-1:0] imm,
    input  acc_size_e     size,
    output logic [AW-1:0] ea,
    output logic [OW-1:0] boff,
    output logic          legal
);

    localparam int unsigned EXT_W = AW - IW;

    logic [AW-1:0] imm_x;

    assign imm_x = {{EXT_W{imm[IW-1]}}, imm};
    assign ea    = base + imm_x;
    assign boff  = ea[OW-1:0];

    // Natural alignment: an N-byte access needs log2(N) low zero bits
    always_comb begin
        unique case (size)
            SZ_BYTE: legal = 1'b1;
            SZ_HALF: legal = ~boff[0];
            SZ_WORD: legal = (boff == '0);
            default: legal = 1'b0;
        endcase
    end

endmodule

// File: rtl/be_store_steer.sv
module be_store_steer
    import be_lsu_pkg::*;
#(
    parameter int unsigned LN = LANES,
    parameter int unsigned BW = BYTE_W,
    parameter int unsigned OW = OFS_W
) (
    input  acc_size_e         size,
    input  logic [OW-1:0]     boff,
    input  logic [LN*BW-1:0]  src,
    output logic [LN-1:0]     be,
    output logic [LN*BW-1:0]  lanes
);

    // Lane g holds byte-address offset LN-1-g (big-endian)
    for (genvar g = 0; g < LN; g++) begin : g_lane
        localparam int unsigned    K  = LN - 1 - g;
        localparam logic [OW-1:0]  KO = OW'(K);
        // Even offset inside a halfword carries its upper byte
        localparam int unsigned    HS = ((K % 2) == 0) ? BW : 0;

        assign be[g] = (size == SZ_BYTE) ? (boff == KO) :
                       (size == SZ_HALF) ? (boff[OW-1:1] == KO[OW-1:1]) :
                       (size == SZ_WORD);

        assign lanes[g*BW +: BW] = (size == SZ_BYTE) ? src[BW-1:0]   :
                                   (size == SZ_HALF) ? src[HS +: BW] :
                                                       src[g*BW +: BW];
    end

endmodule

// File: rtl/be_load_extract.sv
module be_load_extract
    import be_lsu_pkg::*;
#(
    parameter int unsigned LN = LANES,
    parameter int unsigned BW = BYTE_W,
    parameter int unsigned OW = OFS_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  ld_ctx_t           ctx,
    input  logic [LN*BW-1:0]  word,
    output logic [LN*BW-1:0]  result
);

    localparam int unsigned DW = LN * BW;

    logic [LN-1:0][BW-1:0] lane_v;
    logic [OW-1:0]         idx_hi;
    logic [OW-1:0]         idx_lo;
    logic [DW-1:0]         byte_raw;
    logic [DW-1:0]         half_raw;
    logic [DW-1:0]         fresh;
    logic [DW-1:0]         held;

    assign lane_v = word;
    assign idx_hi = OW'(LN - 1) - ctx.boff;
    assign idx_lo = idx_hi - OW'(1);

    assign byte_raw = DW'(lane_v[idx_hi]);
    assign half_raw = DW'({lane_v[idx_hi], lane_v[idx_lo]});

    always_comb begin
        unique case (ctx.size)
            SZ_BYTE: fresh = widen(byte_raw, BW, ctx.sext);
            SZ_HALF: fresh = widen(half_raw, 2 * BW, ctx.sext);
            default: fresh = word;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held <= '0;
        end else if (take) begin
            held <= fresh;
        end
    end

    assign result = take ? fresh : held;

    // R10: result only moves in a response cycle
    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !take |-> $stable(result))
        else $error("result changed without a response");

    // R8: zero-extended byte loads leave upper bits clear
    p_zext_byte_r8: assert property (@(posedge clk) disable iff (rst)
        (take && ctx.size == SZ_BYTE && !ctx.sext) |-> (result[DW-1:BW] == '0))
        else $error("unsigned byte load has upper bits set");

endmodule

// File: rtl/be_lsu_align.sv
module be_lsu_align
    import be_lsu_pkg::*;
#(
    parameter int unsigned DW = XLEN,
    parameter int unsigned IW = IMM_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [1:0]    req_size,
    input  logic          req_signed,
    input  logic [DW-1:0] req_base,
    input  logic [IW-1:0] req_offset,
    input  logic [DW-1:0] req_wdata,
    output logic          mem_en,
    output logic          mem_we,
    output logic [DW-1:0] mem_addr,
    output logic [DW/BYTE_W-1:0] mem_be,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_data,
    output logic          misalign
);

    localparam int unsigned LN = DW / BYTE_W;
    localparam int unsigned OW = $clog2(LN);

    acc_size_e      sz;
    logic [DW-1:0]  ea;
    logic [OW-1:0]  boff;
    logic           legal;
    logic [LN-1:0]  st_be;
    logic [DW-1:0]  st_lanes;
    ld_ctx_t        ctx_q;
    logic           mis_q;

    assign sz = acc_size_e'(req_size);

    be_agen #(.AW(DW), .IW(IW), .OW(OW)) u_agen (
        .base  (req_base),
        .imm   (req_offset),
        .size  (sz),
        .ea    (ea),
        .boff  (boff),
        .legal (legal)
    );

    be_store_steer #(.LN(LN), .BW(BYTE_W), .OW(OW)) u_steer (
        .size  (sz),
        .boff  (boff),
        .src   (req_wdata),
        .be    (st_be),
        .lanes (st_lanes)
    );

    // Memory side, same cycle as the request
    assign mem_en    = req_valid & legal;
    assign mem_we    = mem_en & req_write;
    assign mem_addr  = {ea[DW-1:OW], {OW{1'b0}}};
    assign mem_be    = mem_we ? st_be : '0;
    assign mem_wdata = st_lanes;

    // Request context carried to the response cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            ctx_q <= '0;
            mis_q <= 1'b0;
        end else begin
            ctx_q <= '{load: req_valid & ~req_write & legal,
                       size: sz,
                       sext: req_signed,
                       boff: boff};
            mis_q <= req_valid & ~legal;
        end
    end

    be_load_extract #(.LN(LN), .BW(BYTE_W), .OW(OW)) u_extract (
        .clk    (clk),
        .rst    (rst),
        .take   (ctx_q.load),
        .ctx    (ctx_q),
        .word   (mem_rdata),
        .result (rsp_data)
    );

    assign rsp_valid = ctx_q.load;
    assign misalign  = mis_q;

    // R4: a flagged cycle follows a request that never reached memory
    p_reject_src_r4: assert property (@(posedge clk) disable iff (rst)
        misalign |-> ($past(req_valid) && !$past(mem_en)))
        else $error("misalign without a rejected request");

    // R4: a rejected access never also answers
    p_reject_excl_r4: assert property (@(posedge clk) disable iff (rst)
        misalign |-> !rsp_valid)
        else $error("misalign and rsp_valid together");

    // R9: every response comes from a memory read one cycle earlier
    p_rsp_src_r9: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(mem_en && !mem_we))
        else $error("response without a preceding read");

    // R5: store masks cover one, two or four lanes
    p_mask_shape_r5: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> ($countones(mem_be) == 1 || $countones(mem_be) == 2 ||
                    $countones(mem_be) == LN))
        else $error("store enable mask has bad shape");

endmodule

// File: tb/be_lsu_align_tb.sv
module be_lsu_align_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic        req_write;
    logic [1:0]  req_size;
    logic        req_signed;
    logic [31:0] req_base;
    logic [15:0] req_offset;
    logic [31:0] req_wdata;
    logic        mem_en;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [3:0]  mem_be;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata;
    logic        rsp_valid;
    logic [31:0] rsp_data;
    logic        misalign;

    always #5 clk = ~clk;

    be_lsu_align u_dut (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_size   (req_size),
        .req_signed (req_signed),
        .req_base   (req_base),
        .req_offset (req_offset),
        .req_wdata  (req_wdata),
        .mem_en     (mem_en),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_be     (mem_be),
        .mem_wdata  (mem_wdata),
        .mem_rdata  (mem_rdata),
        .rsp_valid  (rsp_valid),
        .rsp_data   (rsp_data),
        .misalign   (misalign)
    );

    // Reference byte image and the word memory behind the port
    logic [7:0]  bm   [256];
    logic [31:0] tmem [64];

    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) begin
                for (int l = 0; l < 4; l++) begin
                    if (mem_be[l]) tmem[mem_addr[7:2]][8*l +: 8] <= mem_wdata[8*l +: 8];
                end
            end else begin
                mem_rdata <= tmem[mem_addr[7:2]];
            end
        end
    end

    typedef struct {
        bit          rv;
        bit          mis;
        logic [31:0] data;
        string       tag;
    } exp_t;

    exp_t        sbq[$];
    int          n_vec = 0;
    int          n_bad = 0;
    logic [31:0] last_load = 32'h0;
    bit          done = 1'b0;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_load(input logic [31:0] ea, input int nb, input bit sg);
        logic [31:0] v;
        v = 32'h0;
        for (int i = 0; i < nb; i++) v = (v << 8) | 32'(bm[8'(ea + 32'(i))]);
        if (sg && nb < 4 && v[8*nb-1]) begin
            for (int j = 8*nb; j < 32; j++) v[j] = 1'b1;
        end
        return v;
    endfunction

    // Driver: one request per call, expectation pushed for the next cycle
    task automatic req(input bit wr, input logic [1:0] sz, input bit sg,
                       input logic [31:0] base, input logic [15:0] ofs,
                       input logic [31:0] wd, input string tag);
        logic [31:0] ea;
        int          nb;
        bit          legal;
        logic [3:0]  ebe;
        logic [31:0] ewd;
        exp_t        e;
        @(negedge clk);
        req_valid  = 1'b1;
        req_write  = wr;
        req_size   = sz;
        req_signed = sg;
        req_base   = base;
        req_offset = ofs;
        req_wdata  = wd;
        ea    = base + {{16{ofs[15]}}, ofs};
        nb    = (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : (sz == 2'b10) ? 4 : 0;
        legal = (nb != 0) && ((ea % 32'(nb)) == 0);
        #1;
        check(mem_en === legal, tag, "mem_en", 32'(mem_en), 32'(legal));
        check(mem_we === (wr && legal), tag, "mem_we", 32'(mem_we), 32'(wr && legal));
        if (legal) check(mem_addr === {ea[31:2], 2'b00}, tag, "mem_addr", mem_addr, {ea[31:2], 2'b00});
        if (legal && wr) begin
            ebe = 4'b0000;
            for (int i = 0; i < nb; i++) ebe[3 - ((int'(ea[1:0]) + i) % 4)] = 1'b1;
            ewd = (nb == 1) ? {4{wd[7:0]}} : (nb == 2) ? {2{wd[15:0]}} : wd;
            check(mem_be === ebe, tag, "mem_be", 32'(mem_be), 32'(ebe));
            check(mem_wdata === ewd, tag, "mem_wdata", mem_wdata, ewd);
            for (int i = 0; i < nb; i++) bm[8'(ea + 32'(i))] = wd[8*(nb-1-i) +: 8];
        end else if (!legal) begin
            check(mem_be === 4'b0000, tag, "mem_be idle", 32'(mem_be), 32'h0);
        end
        e.rv  = legal && !wr;
        e.mis = !legal;
        if (e.rv) last_load = ref_load(ea, nb, sg);
        e.data = last_load;
        e.tag  = tag;
        sbq.push_back(e);
    endtask

    task automatic idle(input int n, input string tag);
        exp_t e;
        for (int c = 0; c < n; c++) begin
            @(negedge clk);
            req_valid = 1'b0;
            e.rv = 1'b0; e.mis = 1'b0; e.data = last_load; e.tag = tag;
            sbq.push_back(e);
        end
    endtask

    // Monitor: one expectation per cycle after the edge that produced it
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sbq.size() > 0) begin
                exp_t e;
                e = sbq.pop_front();
                check(rsp_valid === e.rv, e.tag, "rsp_valid", 32'(rsp_valid), 32'(e.rv));
                check(misalign === e.mis, e.tag, "misalign", 32'(misalign), 32'(e.mis));
                check(rsp_data === e.data, e.tag, "rsp_data", rsp_data, e.data);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        for (int a = 0; a < 256; a++) bm[a] = 8'(a * 53 + 145);
        for (int w = 0; w < 64; w++) tmem[w] = {bm[4*w], bm[4*w+1], bm[4*w+2], bm[4*w+3]};
        mem_rdata  = 32'h0;
        rst        = 1'b1;
        req_valid  = 1'b0;
        req_write  = 1'b0;
        req_size   = 2'b00;
        req_signed = 1'b0;
        req_base   = 32'h0;
        req_offset = 16'h0;
        req_wdata  = 32'h0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: quiet outputs under reset
        check(rsp_valid === 1'b0, "R1", "rsp_valid", 32'(rsp_valid), 32'h0);
        check(misalign === 1'b0, "R1", "misalign", 32'(misalign), 32'h0);
        check(rsp_data === 32'h0, "R1", "rsp_data", rsp_data, 32'h0);
        check(mem_en === 1'b0 && mem_we === 1'b0, "R1", "mem_en/we", 32'({mem_en, mem_we}), 32'h0);
        rst = 1'b0;
        idle(1, "R1");

        // R7 R9: plain word load from the initial image
        req(0, 2'b10, 0, 32'h40, 16'h0000, 32'h0, "R7");
        // R11: store then load of the same word on consecutive cycles
        req(1, 2'b10, 0, 32'h40, 16'h0004, 32'hC3A5_7E01, "R6");
        req(0, 2'b10, 0, 32'h44, 16'h0000, 32'h0, "R11");
        // R7 R8: bytes at every offset, both extensions
        for (int k = 0; k < 4; k++) begin
            req(0, 2'b00, 1, 32'h44, 16'(k), 32'h0, "R8");
            req(0, 2'b00, 0, 32'h44, 16'(k), 32'h0, "R7");
        end
        // R7 R8: halfwords at both legal offsets
        req(0, 2'b01, 1, 32'h44, 16'h0000, 32'h0, "R8");
        req(0, 2'b01, 0, 32'h44, 16'h0000, 32'h0, "R7");
        req(0, 2'b01, 1, 32'h44, 16'h0002, 32'h0, "R8");
        req(0, 2'b01, 0, 32'h44, 16'h0002, 32'h0, "R7");
        idle(2, "R10");
        // R5 R6: byte stores with junk above bit 7
        for (int k = 0; k < 4; k++) begin
            req(1, 2'b00, 0, 32'h48, 16'(k), 32'hDEAD_BE00 | 32'(8'h81 + 8'(k * 37)), "R5");
        end
        req(0, 2'b10, 0, 32'h48, 16'h0000, 32'h0, "R5");
        // R5 R6: halfword stores at both offsets
        req(1, 2'b01, 0, 32'h4C, 16'h0000, 32'h1234_F00D, "R5");
        req(1, 2'b01, 0, 32'h4C, 16'h0002, 32'hABCD_8001, "R6");
        req(0, 2'b10, 0, 32'h4C, 16'h0000, 32'h0, "R6");
        req(0, 2'b01, 1, 32'h4C, 16'h0002, 32'h0, "R8");
        // R3 R4: every illegal offset, reserved size, both directions
        req(0, 2'b01, 1, 32'h44, 16'h0001, 32'h0, "R3");
        req(0, 2'b01, 0, 32'h44, 16'h0003, 32'h0, "R3");
        req(0, 2'b10, 0, 32'h44, 16'h0001, 32'h0, "R3");
        req(0, 2'b10, 0, 32'h44, 16'h0002, 32'h0, "R3");
        req(0, 2'b10, 0, 32'h44, 16'h0003, 32'h0, "R3");
        req(1, 2'b01, 0, 32'h4C, 16'h0001, 32'hFFFF_FFFF, "R4");
        req(1, 2'b10, 0, 32'h4C, 16'h0002, 32'hFFFF_FFFF, "R4");
        req(0, 2'b11, 0, 32'h4C, 16'h0000, 32'h0, "R3");
        req(1, 2'b11, 0, 32'h4C, 16'h0000, 32'hFFFF_FFFF, "R4");
        idle(1, "R10");
        req(0, 2'b10, 0, 32'h4C, 16'h0000, 32'h0, "R4");
        // R2: negative displacement, wrap past 2^32, large positive
        req(0, 2'b10, 0, 32'h60, 16'hFFE4, 32'h0, "R2");
        req(0, 2'b10, 0, 32'hFFFF_FFF0, 16'h0058, 32'h0, "R2");
        req(0, 2'b01, 1, 32'h0000_0000, 16'h7FFE, 32'h0, "R2");
        req(0, 2'b00, 1, 32'h0000_1000, 16'h8001, 32'h0, "R2");
        // R11: mixed back-to-back traffic
        req(1, 2'b00, 0, 32'h50, 16'h0002, 32'h0000_00F7, "R11");
        req(0, 2'b00, 1, 32'h50, 16'h0002, 32'h0, "R11");
        req(0, 2'b10, 0, 32'h50, 16'h0001, 32'h0, "R4");
        req(0, 2'b10, 0, 32'h50, 16'h0000, 32'h0, "R11");
        idle(3, "R10");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule